// File: doc/BRIEF.md
# Power-Fail Protected Byte Memory with Low-Battery Write Guard

This block is a 2048-byte static memory with active-low chip select, output enable and write strobe inputs. The strobes are sampled on a single clock, and the block works out the access mode from them on every cycle. It has a registered 8-bit read port. A companion flag tells a tristate pad driver when the read port should drive the bus. While the bus is not driven, the read data is held at zero.

A write window opens in the first sampled cycle in which chip select and write strobe are both low. It closes in the first sampled cycle in which either of them has returned high. The byte stored is the data and address present in that closing cycle, so a write may be controlled by either strobe.

A power-fail input overrides everything. While it is high, the bus is released, reads are refused and nothing is stored. A write window that it interrupts is thrown away.

A low-battery guard is loaded when power-good rises. While the guard is set, the next completed write is silently dropped and the guard then clears itself. Software can detect a weak cell by writing a complement and reading it back.

Top module: `wp_sram`

## Requirements
- R1: When a cycle samples chip select low, write strobe high, output enable low and power-fail low, the next cycle shows the enable flag at 1 and read data equal to the byte stored at the sampled address.
- R2: When a cycle samples chip select high, or chip select low with both output enable and write strobe high, the next cycle shows the enable flag at 0.
- R3: A write closes at the first cycle after a window of both strobes low in which either strobe is high. It stores the data and address present in that closing cycle, whichever strobe closed it. A read sampled in the closing cycle returns the earlier content.
- R4: A cycle that samples the write strobe low leaves the enable flag at 0 in the next cycle, even with chip select and output enable low.
- R5: While power-fail is high, the enable flag is 0 in the following cycle, and no write is stored. A write window open when power-fail rises is discarded without storing.
- R6: Reset clears the low-battery guard. Each rising edge of power-good loads the guard from the battery-low input.
- R7: While the guard is set, the next completed write is not stored and clears the guard. The write after it is stored normally.
- R8: A write discarded by power-fail does not clear the guard.
- R9: Stored bytes are kept unchanged across deselected periods and power-fail periods.
- R10: The read data output is zero whenever the enable flag is 0, including directly after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| power_good | input | 1 | Supply valid; rising edge loads the low-battery guard |
| battery_low | input | 1 | Cell weak indication, sampled on power-good rise |
| pf_deselect | input | 1 | Power-fail deselect, overrides all modes |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 11 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero when not driving |
| dout_en | output | 1 | Bus drive enable for the pad tristate |

## Verification
Every address is written and read back in two full sweeps with different arithmetic data patterns. The first sweep uses windows closed by the write strobe and the second uses windows closed by chip select, so the two ways of closing a write are told apart. A swapped address bit or a stuck data bit shows up as a mismatch. In each window the data is changed between the opening and closing cycles, which separates storing at the close from storing at the open. Separate sequences exercise power-fail during a read, during an open write window and across a full sweep. They also exercise the low-battery guard: it survives an aborted write, drops exactly one completed write and then clears.

// File: rtl/wp_sram_pkg.sv
package wp_sram_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_READ  = 2'd2,
    MODE_WRITE = 2'd3
  } acc_mode_t;
endpackage

// File: rtl/wp_sram_ctrl.sv
module wp_sram_ctrl
  import wp_sram_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic pf_deselect,
  output acc_mode_t mode,
  output logic rd_req,
  output logic wr_close,
  output logic drive_en
);
  logic win_open;

  always_comb begin
    if (pf_deselect || ce_n)  mode = MODE_OFF;
    else if (!we_n)           mode = MODE_WRITE;
    else if (!oe_n)           mode = MODE_READ;
    else                      mode = MODE_IDLE;
  end

  assign rd_req   = (mode == MODE_READ);
  // window closes when strobes part while power is fine
  assign wr_close = win_open && (mode != MODE_WRITE) && !pf_deselect;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_open <= 1'b0;
      drive_en <= 1'b0;
    end else begin
      win_open <= (mode == MODE_WRITE);
      drive_en <= rd_req;
    end
  end
endmodule

// File: rtl/wp_sram_batt.sv
module wp_sram_batt (
  input  logic clk,
  input  logic rst,
  input  logic power_good,
  input  logic battery_low,
  input  logic wr_close,
  output logic guard,
  output logic pg_rise,
  output logic commit
);
  logic pg_q;

  assign pg_rise = power_good && !pg_q;
  assign commit  = wr_close && !guard;

  always_ff @(posedge clk) begin
    if (rst) begin
      pg_q  <= 1'b0;
      guard <= 1'b0;
    end else begin
      pg_q <= power_good;
      if (pg_rise)       guard <= battery_low;
      else if (wr_close) guard <= 1'b0;
    end
  end
endmodule

// File: rtl/wp_sram_array.sv
module wp_sram_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/wp_sram.sv
module wp_sram
  import wp_sram_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          power_good,
  input  logic          battery_low,
  input  logic          pf_deselect,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en
);
  acc_mode_t     mode;
  logic          rd_req, wr_close, guard, pg_rise, commit;
  logic [DW-1:0] rdata;

  wp_sram_ctrl u_ctrl (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .pf_deselect(pf_deselect), .mode(mode), .rd_req(rd_req),
    .wr_close(wr_close), .drive_en(dout_en)
  );

  wp_sram_batt u_batt (
    .clk(clk), .rst(rst), .power_good(power_good), .battery_low(battery_low),
    .wr_close(wr_close), .guard(guard), .pg_rise(pg_rise), .commit(commit)
  );

  wp_sram_array #(.AW(AW), .DW(DW)) u_array (
    .clk(clk), .we(commit), .waddr(addr), .wdata(din),
    .re(rd_req), .raddr(addr), .rdata(rdata)
  );

  assign dout = dout_en ? rdata : '0;
endmodule

// File: rtl/wp_sram_chk.sv
module wp_sram_chk (
  input logic clk,
  input logic rst,
  input logic pf_deselect,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic dout_en,
  input logic guard,
  input logic pg_rise,
  input logic wr_close,
  input logic commit
);
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !oe_n && we_n && !pf_deselect) |=> dout_en); // R1
  AST_DESELECT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (ce_n || (oe_n && we_n)) |=> !dout_en); // R2
  AST_STROBE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !we_n |=> !dout_en); // R4
  AST_PF_RELEASE: assert property (@(posedge clk) disable iff (rst)
    pf_deselect |=> !dout_en); // R5
  AST_PF_NO_STORE: assert property (@(posedge clk) disable iff (rst)
    pf_deselect |-> !commit); // R5
  AST_GUARD_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(guard) |-> $past(wr_close || pg_rise)); // R7
endmodule

bind wp_sram wp_sram_chk u_chk (
  .clk(clk), .rst(rst), .pf_deselect(pf_deselect), .ce_n(ce_n), .oe_n(oe_n),
  .we_n(we_n), .dout_en(dout_en), .guard(guard), .pg_rise(pg_rise),
  .wr_close(wr_close), .commit(commit)
);

// File: tb/tb_wp_sram.sv
module tb_wp_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst, power_good, battery_low, pf_deselect, ce_n, oe_n, we_n;
  logic [AW-1:0] addr;
  logic [7:0] din, dout;
  logic dout_en;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [7:0] model [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_sram dut (
    .clk(clk), .rst(rst), .power_good(power_good), .battery_low(battery_low),
    .pf_deselect(pf_deselect), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [7:0] pat(input int a, input bit inv);
    logic [7:0] v;
    v = 8'((a * 13) + ((a >> 8) * 71) + 5);
    return inv ? ~v : v;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    ce_n = 1; oe_n = 1; we_n = 1;
  endtask

  task automatic do_read(input int a, output logic [7:0] d, output logic e);
    ce_n = 0; oe_n = 0; we_n = 1; addr = AW'(a);
    tick();
    d = dout; e = dout_en;
    idle();
    tick();
  endtask

  task automatic write_by_we(input int a, input logic [7:0] d);
    oe_n = 1; ce_n = 0; we_n = 0; addr = AW'(a); din = ~d;
    tick();
    din = d; we_n = 1;
    tick();
    ce_n = 1;
    tick();
  endtask

  task automatic write_by_ce(input int a, input logic [7:0] d);
    oe_n = 1; we_n = 0; ce_n = 1; addr = AW'(a); din = ~d;
    tick();
    ce_n = 0;
    tick();
    din = d; ce_n = 1;
    tick();
    we_n = 1;
    tick();
  endtask

  task automatic read_check(input string req, input int a);
    logic [7:0] d;
    logic e;
    do_read(a, d, e);
    check(req, {7'd0, e}, 8'd1);
    check(req, d, model[a]);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin
    rst = 1; power_good = 0; battery_low = 0; pf_deselect = 0;
    idle(); addr = '0; din = '0;
    repeat (3) tick();
    // R10 R2: reset state
    check("R10 reset dout", dout, 8'h00);
    check("R2 reset dout_en", {7'd0, dout_en}, 8'd0);
    rst = 0;
    power_good = 1;   // R6: rise with cell fine, guard stays clear
    tick(); tick();

    // R3 R1: sweep with strobe-closed writes
    for (int a = 0; a < DEPTH; a++) begin
      write_by_we(a, pat(a, 0));
      model[a] = pat(a, 0);
    end
    for (int a = 0; a < DEPTH; a++) read_check("R1 R3 sweep we", a);

    // R2: chip select high with output enable low
    ce_n = 1; oe_n = 0; we_n = 1; addr = 11'd9;
    tick();
    check("R2 ce high", {7'd0, dout_en}, 8'd0);
    check("R10 ce high dout", dout, 8'h00);
    // R2: selected, both output enable and strobe high
    ce_n = 0; oe_n = 1;
    tick();
    check("R2 oe we high", {7'd0, dout_en}, 8'd0);
    idle(); tick();

    // R4: write strobe falls during a driven read
    ce_n = 0; oe_n = 0; we_n = 1; addr = 11'd7; din = model[7];
    tick();
    check("R4 before strobe", {7'd0, dout_en}, 8'd1);
    we_n = 0;
    tick();
    check("R4 strobe low", {7'd0, dout_en}, 8'd0);
    check("R10 strobe low dout", dout, 8'h00);
    we_n = 1;
    tick();
    // R3: read in the closing cycle sees the earlier content
    check("R3 close-cycle read", dout, model[7]);
    idle(); tick();

    // R5: power-fail during a read request
    pf_deselect = 1; ce_n = 0; oe_n = 0; we_n = 1; addr = 11'd7;
    tick();
    check("R5 pf read", {7'd0, dout_en}, 8'd0);
    idle(); pf_deselect = 0; tick();

    // R6: power cycle with weak cell sets the guard
    power_good = 0; tick();
    battery_low = 1; power_good = 1; tick();
    battery_low = 0; tick();

    // R5 R8: open window aborted by power-fail
    oe_n = 1; ce_n = 0; we_n = 0; addr = 11'd7; din = 8'hA5;
    tick();
    pf_deselect = 1;
    tick();
    idle();
    tick();
    pf_deselect = 0;
    tick();
    read_check("R5 aborted write", 7);

    // R7 R8: guard still set, this write is dropped
    write_by_we(7, ~model[7]);
    read_check("R7 R8 first write dropped", 7);
    // R7: guard cleared, next write stored
    write_by_we(7, ~model[7]);
    model[7] = ~model[7];
    read_check("R7 second write stored", 7);

    // R3: chip-select-closed sweep with complement pattern
    for (int a = 0; a < DEPTH; a++) begin
      write_by_ce(a, pat(a, 1));
      model[a] = pat(a, 1);
    end

    // R5 R9: writes attempted under power-fail do nothing
    pf_deselect = 1;
    for (int a = 0; a < 64; a++) write_by_we(a * 31, 8'h3C);
    pf_deselect = 0;
    repeat (20) tick();   // R9: long deselect
    for (int a = 0; a < DEPTH; a++) read_check("R3 R5 R9 sweep ce", a);

    finish_up();
  end
endmodule